// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a shallow last-in, first-out store of one-byte status records for transmissions that have finished. When a packet leaves, the transmit engine offers a status record. The record is kept only if the packet ended with a fault or if the packet asked for an interrupt on success. Clean packets that asked for no interrupt leave nothing behind.

The host always sees the most recently stored record on the read port. Any write strobe on the port removes that record. While at least one record is held, a completion event line stays high. A jabber or underrun fault sets a halt latch that keeps the transmitter stopped. Only a transmit reset clears that latch, and the same reset also empties the store. When the store is full, a new record is lost, and the record on top is marked to show the loss.

Top module: `txstat_stack`

## Requirements
- R1: A stored record has this layout: bit 7 = 1 (done), bit 6 = success interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = collision limit reached, bit 2 = records were lost, and bits 1:0 = 0.
- R2: An offered record with no jabber, no underrun, no collision limit and no interrupt request is not stored.
- R3: Records leave in last-in, first-out order. `rd_data` shows the newest record, and a cycle with `host_wr` high removes it.
- R4: When the store is empty, `rd_data` reads 0x00 and `host_wr` changes nothing.
- R5: A record that would be stored while `DEPTH` records are already held is discarded. Bit 2 of the top record is set, and the older records stay unchanged.
- R6: `tx_cmpl_evt` is high exactly while at least one record is held.
- R7: An offered record with jabber or underrun sets `tx_halt` on the next edge. `tx_halt` then stays high through pops and later pushes until a transmit reset.
- R8: `tx_reset` empties the store and clears `tx_halt`. It overrides a push or pop in the same cycle.
- R9: A push and a pop in the same cycle replace the top record, and the count does not change. When the store is full, such a push is accepted and sets no loss bit.
- R10: After `rst_n` is released, the store is empty and `tx_halt` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_vld | input | 1 | Transmit engine offers a status record this cycle |
| push_intr | input | 1 | Packet asked for an interrupt on success |
| push_jab | input | 1 | Jabber fault |
| push_und | input | 1 | Underrun fault |
| push_maxcol | input | 1 | Collision limit reached |
| host_wr | input | 1 | Host write strobe to the status port (pops the record) |
| tx_reset | input | 1 | Transmit reset command |
| rd_data | output | 8 | Top record, or 0 when empty |
| tx_cmpl_evt | output | 1 | High while any record is held |
| tx_halt | output | 1 | Fault latch that holds the transmitter off |

## Verification
A wrong count or a wrong top index shows up at `rd_data` in the cycle after the push or pop that caused it. The symptom is a stale record, a zero read while the event line is high, or records popping in the wrong order. A loss bit placed in the wrong slot stays hidden until the host pops down to that slot. For that reason the bench empties the store completely after each overflow. A halt latch that is lost or cleared too early appears on `tx_halt` one edge after the fault, or one edge after a pop. The scoreboard compares all three outputs after every cycle.

// File: rtl/txstat_stack.sv
module txstat_stack #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_vld,
  input  logic       push_intr,
  input  logic       push_jab,
  input  logic       push_und,
  input  logic       push_maxcol,
  input  logic       host_wr,
  input  logic       tx_reset,
  output logic [7:0] rd_data,
  output logic       tx_cmpl_evt,
  output logic       tx_halt
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    stk [DEPTH];
  logic [CW-1:0] cnt, cnt_pop, cnt_nxt;
  logic [IW-1:0] top_idx, wr_idx;
  logic          pop_ok, keep, fatal, room, wr_en, ovf_mark;
  logic [7:0]    entry;

  assign fatal    = push_jab | push_und;
  assign keep     = push_vld & (push_intr | fatal | push_maxcol);
  assign entry    = {1'b1, push_intr, push_jab, push_und, push_maxcol, 3'b000};
  assign pop_ok   = host_wr && (cnt != '0);
  assign cnt_pop  = cnt - CW'(pop_ok);
  assign room     = cnt_pop < CW'(DEPTH);
  assign wr_en    = keep & room;
  assign ovf_mark = keep & ~room;
  assign cnt_nxt  = cnt_pop + CW'(wr_en);
  assign wr_idx   = IW'(cnt_pop);
  assign top_idx  = IW'(cnt - CW'(1));

  assign tx_cmpl_evt = (cnt != '0);
  assign rd_data     = tx_cmpl_evt ? stk[top_idx] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      tx_halt <= 1'b0;
    end else if (tx_reset) begin
      cnt     <= '0;
      tx_halt <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (push_vld && fatal) tx_halt <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!tx_reset) begin
      if (wr_en)         stk[wr_idx]  <= entry;
      else if (ovf_mark) stk[top_idx] <= stk[top_idx] | 8'h04;
    end
  end
endmodule

module txstat_stack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       push_vld,
  input logic       push_jab,
  input logic       push_und,
  input logic       host_wr,
  input logic       tx_reset,
  input logic [7:0] rd_data,
  input logic       tx_cmpl_evt,
  input logic       tx_halt
);
  p_layout_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] == 2'b00);
  p_evt_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cmpl_evt |-> rd_data[7]);
  p_evt_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_cmpl_evt |-> rd_data == 8'h00);
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_cmpl_evt && host_wr && !push_vld) |=> !tx_cmpl_evt);
  p_halt_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halt) |-> $past(push_vld && (push_jab || push_und)));
  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_halt && !tx_reset) |=> tx_halt);
  p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> (!tx_cmpl_evt && !tx_halt));
endmodule

bind txstat_stack txstat_stack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_jab(push_jab),
  .push_und(push_und), .host_wr(host_wr), .tx_reset(tx_reset),
  .rd_data(rd_data), .tx_cmpl_evt(tx_cmpl_evt), .tx_halt(tx_halt)
);

// File: tb/txstat_stack_tb.sv
`timescale 1ns/1ps
module txstat_stack_tb_top;
  localparam int D = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_vld = 0, push_intr = 0, push_jab = 0, push_und = 0, push_maxcol = 0;
  logic host_wr = 0, tx_reset = 0;
  logic [7:0] rd_data;
  logic tx_cmpl_evt, tx_halt;

  always #2.5 clk = ~clk;

  txstat_stack #(.DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_intr(push_intr),
    .push_jab(push_jab), .push_und(push_und), .push_maxcol(push_maxcol),
    .host_wr(host_wr), .tx_reset(tx_reset), .rd_data(rd_data),
    .tx_cmpl_evt(tx_cmpl_evt), .tx_halt(tx_halt)
  );

  typedef struct {
    logic [7:0] rd;
    logic       evt;
    logic       halt;
    string      tag;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] ms[$];
  bit         mhalt = 0;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  task automatic check(input logic [7:0] rd, input logic evt, input logic halt, input string tag);
    n_chk++;
    if (rd_data !== rd || tx_cmpl_evt !== evt || tx_halt !== halt) begin
      n_fail++;
      $display("FAIL %s: rd=%02h evt=%0b halt=%0b expected rd=%02h evt=%0b halt=%0b",
               tag, rd_data, tx_cmpl_evt, tx_halt, rd, evt, halt);
    end
  endtask

  task automatic op(input logic pv, input logic i, input logic j, input logic u,
                    input logic m, input logic wr, input logic rs, input string tag);
    exp_t e;
    bit keep;
    @(negedge clk);
    push_vld = pv; push_intr = i; push_jab = j; push_und = u; push_maxcol = m;
    host_wr = wr; tx_reset = rs;
    if (rs) begin
      ms.delete(); mhalt = 0;
    end else begin
      if (pv && (j || u)) mhalt = 1;
      keep = pv && (i || j || u || m);
      if (wr && ms.size() > 0) void'(ms.pop_back());
      if (keep) begin
        if (ms.size() < D) ms.push_back({1'b1, i, j, u, m, 3'b000});
        else ms[ms.size()-1] = ms[ms.size()-1] | 8'h04;
      end
    end
    e.rd   = (ms.size() > 0) ? ms[ms.size()-1] : 8'h00;
    e.evt  = ms.size() > 0;
    e.halt = mhalt;
    e.tag  = tag;
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    push_vld = 0; push_intr = 0; push_jab = 0; push_und = 0; push_maxcol = 0;
    host_wr = 0; tx_reset = 0;
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.rd, e.evt, e.halt, e.tag);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(8'h00, 1'b0, 1'b0, "R10 reset state");
    @(negedge clk) rst_n = 1'b1;
    op(0,0,0,0,0,1,0, "R4 pop on empty");
    op(1,0,0,0,0,0,0, "R2 clean packet not stored");
    op(1,1,0,0,0,0,0, "R1 intr record C0");
    op(1,0,0,0,1,0,0, "R1 maxcol record 88");
    op(0,0,0,0,0,1,0, "R3 pop newest");
    op(0,0,0,0,0,1,0, "R3 pop older");
    op(0,0,0,0,0,1,0, "R4 pop empty again");
    op(1,1,0,0,1,0,0, "R6 fill 1");
    op(1,1,0,0,0,0,0, "R6 fill 2");
    op(1,0,0,0,1,0,0, "R6 fill 3");
    op(1,1,0,0,1,0,0, "R6 fill 4");
    op(1,1,0,0,0,0,0, "R5 push when full dropped");
    op(1,0,0,0,0,0,0, "R2 clean push when full ignored");
    op(0,0,0,0,0,1,0, "R5 pop after overflow");
    op(0,0,0,0,0,1,0, "R5 older intact 3");
    op(0,0,0,0,0,1,0, "R5 older intact 2");
    op(0,0,0,0,0,1,0, "R5 last pop");
    op(1,0,0,1,0,0,0, "R7 underrun sets halt");
    op(0,0,0,0,0,1,0, "R7 halt survives pop");
    op(1,1,0,0,0,0,0, "R7 halt survives push");
    op(1,0,0,0,1,1,0, "R9 push and pop replace top");
    op(1,1,0,0,0,0,1, "R8 reset beats push");
    op(1,0,1,0,0,0,0, "R7 jabber sets halt R1 A0");
    op(1,1,0,0,0,0,0, "R9 fill 2");
    op(1,1,0,0,1,0,0, "R9 fill 3");
    op(1,0,0,0,1,0,0, "R9 fill 4");
    op(1,1,0,1,0,1,0, "R9 push and pop when full");
    op(0,0,0,0,0,1,1, "R8 reset beats pop");
    op(0,0,0,0,0,0,0, "R8 idle after reset");
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule